// File: doc/BRIEF.md
# Gated Programmable Clock Divider

The block divides an input clock by a value held in a small register file and gates the result with an enable bit. Software writes a divisor field and an enable bit, and polls a status register. The divided clock comes from a flop, so it is glitch-free. For a divisor of one, the block switches to passing the input clock through.

A divisor write does not take effect at once. The block holds it as pending and raises busy. It applies the new value at the next period boundary, so no period is ever cut short or stretched. Turning the gate on or off is deferred to the low phase of the divided clock, so every high pulse the block emits has its full width.

The field is five bits by default. When the `PRE_EN` parameter is set, a sixth bit is added. Setting that bit switches in a fixed divide-by-64 stage, which scales the low five bits. In both widths an all-zero field selects the largest plain divisor.

Top module: `gated_clk_div`

## Requirements
- R1: With `PRE_EN=0`, a field value v in 2..31 gives an output period of v input cycles.
- R2: A field value of zero gives a period of 32 input cycles with `PRE_EN=0`, and 64 with `PRE_EN=1`.
- R3: With `PRE_EN=1`, field bit 5 set gives a period of 64 × bits[4:0] input cycles, and 64 when bits[4:0] are zero. With bit 5 clear, the period is the value itself, as in R1.
- R4: For a divisor N ≥ 2, the output is high for floor(N/2) input cycles and low for ceil(N/2). Each high phase begins the period.
- R5: With an effective divisor of 1 and the gate on, `clk_o` follows `clk_i`: high in its high half, low in its low half.
- R6: Address 1, bit 0 is the gate enable. While the applied gate is off, `clk_o` stays low. Reading address 1 returns the applied gate state in bit 0.
- R7: A gate change is applied only while the divided output is low. The pulse in progress when the gate is turned off completes at full width. The first pulse after the gate is turned on has full width.
- R8: Address 2 reads 0x18 (bits 3 and 4 set, all other bits 0) from the clock edge that captures a divisor write until the new divisor is applied. At all other times it reads 0.
- R9: A pending divisor is applied only at the end of the current output period. Busy clears on the same input edge on which the first high phase of the new period starts.
- R10: Reading address 0 returns the last written field value in its low bits.
- R11: After reset, addresses 0, 1 and 2 read 0, `clk_o` is low, and the active divisor is the one that a zero field selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe, sampled on the rising edge of `clk_i` |
| addr_i | input | 2 | Register address: 0 divisor field, 1 gate enable, 2 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| clk_o | output | 1 | Divided, gated clock |

## Verification
The bench targets these corner cases:

- **Zero field.** An all-zero field in both widths exposes a decoder that treats zero literally and would divide by zero or by one.
- **Predivider fields.** The fields 0x20, 0x21, 0x23 and 0x3F catch a predivider that adds instead of multiplies, or that mishandles a zero low part.
- **Odd divisors and bypass.** Odd divisors catch an inverted duty split. The divisor of 1 catches an output stuck low where the input clock should pass through.
- **Switch and gate timing.** The bench checks that busy clears on the exact edge the new period starts. It also times pulses around gate changes. An early divisor switch, or a gate applied mid-pulse, shows up as a truncated high phase or a mistimed busy flag.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int DATA_W      = 8;
  localparam int BUSY_LO_BIT = 3;
  localparam int BUSY_HI_BIT = 4;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_GATE = 2'd1,
    REG_STAT = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/gcd_regs.sv
module gcd_regs
  import gcd_pkg::*;
#(
  parameter int FIELD_W   = 5,
  parameter int RST_FIELD = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               switch_i,
  input  logic               gate_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               pend_o,
  output logic               en_o
);
  logic [FIELD_W-1:0] field_q;
  logic pend_q, en_q;
  logic div_wr, gate_wr;
  logic unused_wdata;

  assign div_wr  = wr_i && (addr_i == REG_DIV);
  assign gate_wr = wr_i && (addr_i == REG_GATE);
  assign unused_wdata = ^wdata_i[DATA_W-1:FIELD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= FIELD_W'(RST_FIELD);
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (div_wr) begin
        field_q <= wdata_i[FIELD_W-1:0];
        pend_q  <= 1'b1;   // a late write wins over a same-cycle switch
      end else if (switch_i) begin
        pend_q  <= 1'b0;
      end
      if (gate_wr) en_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DIV:  rdata_o[FIELD_W-1:0] = field_q;
      REG_GATE: rdata_o[0] = gate_i;
      REG_STAT: begin
        rdata_o[BUSY_LO_BIT] = pend_q;
        rdata_o[BUSY_HI_BIT] = pend_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign field_o = field_q;
  assign pend_o  = pend_q;
  assign en_o    = en_q;

  assert_busy_set_by_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(div_wr));
  assert_busy_clear_on_switch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(switch_i));
endmodule

// File: rtl/gcd_core.sv
module gcd_core #(
  parameter int BASE_W    = 5,
  parameter int PRE_EN    = 0,
  parameter int RST_FIELD = 0,
  localparam int FIELD_W  = BASE_W + ((PRE_EN != 0) ? 1 : 0),
  localparam int PRE_SH   = BASE_W + 1,
  localparam int CNT_W    = (PRE_EN != 0) ? (2 * BASE_W + 1) : (BASE_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               pend_i,
  input  logic               en_i,
  output logic               div_clk_o,
  output logic               gate_o,
  output logic               bypass_o,
  output logic               switch_o
);
  function automatic logic [CNT_W-1:0] decode(input logic [FIELD_W-1:0] f);
    logic [BASE_W-1:0] low;
    low = f[BASE_W-1:0];
    if (PRE_EN != 0 && f[FIELD_W-1]) begin
      if (low == '0) decode = CNT_W'(1) << PRE_SH;
      else           decode = CNT_W'(low) << PRE_SH;
    end else if (f == '0) begin
      decode = CNT_W'(1) << FIELD_W;
    end else begin
      decode = CNT_W'(f);
    end
  endfunction

  logic [CNT_W-1:0] cnt_q, n_q, cnt_nxt, n_nxt;
  logic wrap, phase_nxt, gate_q, gate_nxt, div_clk_q, byp_q;

  assign wrap      = (cnt_q == n_q - CNT_W'(1));
  assign switch_o  = wrap && pend_i;
  assign n_nxt     = switch_o ? decode(field_i) : n_q;
  assign cnt_nxt   = wrap ? '0 : cnt_q + CNT_W'(1);
  assign phase_nxt = (cnt_nxt < (n_nxt >> 1));
  assign gate_nxt  = phase_nxt ? gate_q : en_i;  // gate moves only in low phase

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      n_q       <= decode(FIELD_W'(RST_FIELD));
      gate_q    <= 1'b0;
      div_clk_q <= 1'b0;
      byp_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      n_q       <= n_nxt;
      gate_q    <= gate_nxt;
      div_clk_q <= phase_nxt && gate_nxt;
      byp_q     <= (n_nxt == CNT_W'(1));
    end
  end

  assign div_clk_o = div_clk_q;
  assign gate_o    = gate_q;
  assign bypass_o  = byp_q;

  assert_pulse_opens_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_clk_q) |-> (cnt_q == '0));
  assert_high_within_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clk_q |-> (cnt_q < (n_q >> 1)));
  assert_div_moves_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_q) |-> $past(switch_o));
  assert_gate_moves_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> !div_clk_q);
endmodule

// File: rtl/gcd_out.sv
module gcd_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_clk_i,
  input  logic gate_i,
  input  logic bypass_i,
  output logic clk_o
);
  logic byp_n, gate_n;

  // resampled on the falling edge so the bypass path only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_n  <= 1'b0;
      gate_n <= 1'b0;
    end else begin
      byp_n  <= bypass_i;
      gate_n <= gate_i;
    end
  end

  assign clk_o = byp_n ? (clk_i & gate_n) : div_clk_i;

  assert_bypass_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_n |-> !div_clk_i);
endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
  import gcd_pkg::*;
#(
  parameter int BASE_W    = 5,
  parameter int PRE_EN    = 0,
  parameter int RST_FIELD = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_o
);
  localparam int FIELD_W = BASE_W + ((PRE_EN != 0) ? 1 : 0);

  logic [FIELD_W-1:0] field;
  logic pend, en, switch_s, gate, div_clk, bypass;

  gcd_regs #(.FIELD_W(FIELD_W), .RST_FIELD(RST_FIELD)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .switch_i(switch_s), .gate_i(gate),
    .rdata_o(rdata_o), .field_o(field), .pend_o(pend), .en_o(en)
  );

  gcd_core #(.BASE_W(BASE_W), .PRE_EN(PRE_EN), .RST_FIELD(RST_FIELD)) core_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .field_i(field), .pend_i(pend),
    .en_i(en), .div_clk_o(div_clk), .gate_o(gate), .bypass_o(bypass),
    .switch_o(switch_s)
  );

  gcd_out out_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_clk_i(div_clk), .gate_i(gate),
    .bypass_i(bypass), .clk_o(clk_o)
  );
endmodule

// File: tb/gated_clk_div_tb_top.sv
module gated_clk_div_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int TMO = 6000;
  localparam int NV = 11;
  // sel, field, period, high
  localparam int VSEL[NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int VFLD[NV] = '{2, 31, 0, 4, 5, 0, 32, 33, 35, 31, 63};
  localparam int VPER[NV] = '{2, 31, 32, 4, 5, 64, 64, 64, 192, 31, 1984};
  localparam int VHI[NV]  = '{1, 15, 16, 2, 2, 32, 32, 32, 96, 15, 992};

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata5, rdata6, rd;
  logic clk5, clk6, obs;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_clk_div dut_i (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr & ~sel), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata5), .clk_o(clk5));
  gated_clk_div #(.PRE_EN(1)) dut_pre_i (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr & sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata6), .clk_o(clk6));

  assign obs = sel ? clk6 : clk5;
  assign rd  = sel ? rdata6 : rdata5;

  task automatic tick; @(posedge clk); #(CLK_PERIOD/4); endtask

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rd);
  endtask

  task automatic wr_reg(input logic [1:0] a, input int d);
    addr = a; wdata = 8'(d); wr = 1'b1; tick; wr = 1'b0;
  endtask

  task automatic wait_busy_clear;
    int v;
    for (int k = 0; k < TMO; k++) begin rd_reg(2'd2, v); if (v == 0) break; tick; end
  endtask

  task automatic measure(output int per, output int hi);
    int k = 0, lo = 0;
    hi = 0;
    while (obs !== 1'b0 && k < TMO) begin tick; k++; end
    while (obs !== 1'b1 && k < TMO) begin tick; k++; end
    while (obs === 1'b1 && k < TMO) begin hi++; tick; k++; end
    while (obs === 1'b0 && k < TMO) begin lo++; tick; k++; end
    per = hi + lo;
  endtask

  task automatic high_run(output int hi);
    int k = 0;
    hi = 0;
    while (obs !== 1'b1 && k < TMO) begin tick; k++; end
    while (obs === 1'b1 && k < TMO) begin hi++; tick; k++; end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    int v, per, hi, prev, bad;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R11 reset state on both variants
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      for (int a = 0; a < 3; a++) begin rd_reg(2'(a), v); check(v, 0, "R11 reset register"); end
    end
    // R6 gate off: output stays low
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      sel = 1'b0; #1; if (obs !== 1'b0) bad++;
      sel = 1'b1; #1; if (obs !== 1'b0) bad++;
      tick;
    end
    check(bad, 0, "R6 gated-off output high samples");
    sel = 1'b0; wr_reg(2'd1, 1);
    sel = 1'b1; wr_reg(2'd1, 1);
    // R7 first pulse after enable is full; R11 reset divisor is 32
    sel = 1'b0;
    high_run(hi);
    check(hi, 16, "R7 R11 first pulse width");
    rd_reg(2'd1, v); check(v, 1, "R6 gate readback");

    for (int i = 0; i < NV; i++) begin
      sel = VSEL[i][0];
      wr_reg(2'd0, VFLD[i]);
      rd_reg(2'd2, v); check(v, 8'h18, "R8 busy after write");
      prev = int'(obs);
      for (int k = 0; k < TMO; k++) begin
        tick;
        rd_reg(2'd2, v);
        if (v == 0) begin
          check(int'(obs), 1, "R9 new period starts with busy clear");
          check(prev, 0, "R9 old period ended low");
          break;
        end
        prev = int'(obs);
      end
      rd_reg(2'd0, v); check(v, VFLD[i], "R10 field readback");
      measure(per, hi);
      check(per, VPER[i], sel ? "R2 R3 period" : "R1 R2 period");
      check(hi, VHI[i], "R4 high phase");
    end

    // R7 disable during a pulse on the divide-by-5 variant
    sel = 1'b0;
    for (int k = 0; k < TMO && obs !== 1'b0; k++) tick;
    for (int k = 0; k < TMO && obs !== 1'b1; k++) tick;
    hi = 1;
    wr_reg(2'd1, 0);
    while (obs === 1'b1 && hi < TMO) begin hi++; tick; end
    check(hi, 2, "R7 pulse completes after disable");
    bad = 0;
    for (int i = 0; i < 20; i++) begin if (obs !== 1'b0) bad++; tick; end
    check(bad, 0, "R6 output low while disabled");
    rd_reg(2'd1, v); check(v, 0, "R6 gate readback off");
    wr_reg(2'd1, 1);
    high_run(hi);
    check(hi, 2, "R7 first pulse after enable");

    // R5 divide by one
    wr_reg(2'd0, 1);
    wait_busy_clear;
    repeat (3) tick;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      if (obs !== 1'b1) bad++;
      #(CLK_PERIOD/2); if (obs !== 1'b0) bad++;
      tick;
    end
    check(bad, 0, "R5 bypass follows input clock");
    wr_reg(2'd1, 0);
    repeat (3) tick;
    bad = 0;
    for (int i = 0; i < 6; i++) begin if (obs !== 1'b0) bad++; tick; end
    check(bad, 0, "R5 R6 bypass gated off");

    done = 1;
    summary;
    $finish;
  end
endmodule